// File: doc/BRIEF.md
# Block Floating Point Shift Tracker

This block takes a stream of words grouped into vectors and normalizes them in block floating point style. Each vector is one pass. While the words of a pass stream through, the block measures how far each word could be shifted left before its leading significant digit reaches the top bit. It keeps the smallest of those distances for the vector in a register, which is fed by a comparator. Taking the smallest distance means the word of largest magnitude sets the shared shift, so no word loses its leading digit.

The block does not wait for that measurement before it shifts. Every word of the current pass is shifted left by the shared value that was measured over the previous pass. So measuring and applying run side by side, one pass apart. The per-word shift result is never fed straight back into the shifter.

The input side has a valid strobe, first-word and last-word markers, a data word and a sign bit. The sign bit selects whether leading zeros or leading ones count as insignificant. The output is registered one cycle after the input. With the shifted word it carries the markers, the shift that was applied, and the block shift measured so far.

Top module: `bfp_shift_tracker`

## Requirements
- R1: While reset is asserted and after its release, `out_valid`, `out_first` and `out_last` are 0, `out_shift` is 0 and `out_meas` is W-1. The applied shift starts at 0, so the words of the first vector leave unshifted.
- R2: Every output is registered with one cycle of latency. `out_valid` equals `in_valid` of the previous cycle, and `out_first`/`out_last` equal `in_first`/`in_last` of the previous cycle when it was valid, else 0.
- R3: The measured distance of a word is the number of its leading bits, counted from bit W-1 downward, that equal `in_sign`. If every bit equals `in_sign`, or only bit 0 differs, the distance is W-1.
- R4: After a word is accepted, `out_meas` is the minimum measured distance over the words of its vector from the first-marked word up to and including this one. A first-marked word reloads the minimum rather than comparing with the old value.
- R5: When a last-marked word is accepted, the minimum that includes that word becomes the applied shift for every word of the following vectors until the next last-marked word. `out_shift` reports that applied shift alongside each word.
- R6: `out_data` equals the raw `in_data` of the word, not inverted by the sign, shifted left by `out_shift` with zeros filling the low bits.
- R7: A cycle with `in_valid` low changes neither the running minimum (`out_meas`), nor the applied shift, nor `out_data`.
- R8: A vector of one word, with first and last marked together, takes its own distance as both the minimum and the next applied shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word valid |
| in_first | input | 1 | Word is the first of its vector |
| in_last | input | 1 | Word is the last of its vector |
| in_data | input | W | Input word |
| in_sign | input | 1 | Sign of the word; leading bits equal to it are insignificant |
| out_valid | output | 1 | Output word valid |
| out_first | output | 1 | Output word is first of its vector |
| out_last | output | 1 | Output word is last of its vector |
| out_data | output | W | Word shifted left by the applied shift |
| out_shift | output | SW | Shift applied to this word |
| out_meas | output | SW | Running minimum distance of the current vector |

## Verification
On every cycle the assertions check four things: the valid latency; that idle cycles leave the minimum and the data alone; that the minimum never rises within a vector; and that the applied shift moves only on a last-marked word. They also check that the low bits vacated by the shift are always zero. The exact distance for each leading-digit position and sign, and the exact minimum over a vector, can only be shown by the bench. The same holds for the hand-over of that minimum to the whole next vector, and for the single-word vectors. The bench covers these with a sweep over every digit position and both signs, followed by random vectors with gaps.

// File: rtl/bfp_shift_tracker.sv
module bfp_shift_tracker #(
  parameter int W = 32,
  localparam int SW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_first,
  input  logic          in_last,
  input  logic [W-1:0]  in_data,
  input  logic          in_sign,
  output logic          out_valid,
  output logic          out_first,
  output logic          out_last,
  output logic [W-1:0]  out_data,
  output logic [SW-1:0] out_shift,
  output logic [SW-1:0] out_meas
);

  logic [W-1:0]  mag;
  logic [SW-1:0] lead, cand, run_min, app_shift;

  assign mag = in_data ^ {W{in_sign}};

  always_comb begin
    lead = SW'(W - 1);
    for (int i = 0; i < W; i++)
      if (mag[i]) lead = SW'(W - 1 - i);
  end

  assign cand     = (in_first || lead < run_min) ? lead : run_min;
  assign out_meas = run_min;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_min   <= SW'(W - 1);
      app_shift <= '0;
      out_valid <= 1'b0;
      out_first <= 1'b0;
      out_last  <= 1'b0;
      out_data  <= '0;
      out_shift <= '0;
    end else begin
      out_valid <= in_valid;
      out_first <= in_valid & in_first;
      out_last  <= in_valid & in_last;
      if (in_valid) begin
        run_min   <= cand;
        out_data  <= in_data << app_shift;
        out_shift <= app_shift;
        if (in_last) app_shift <= cand;
      end
    end
  end

endmodule

// File: rtl/bfp_shift_tracker_chk.sv
module bfp_shift_tracker_chk #(
  parameter int W = 32,
  localparam int SW = $clog2(W)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_first,
  input logic          in_last,
  input logic          out_valid,
  input logic [W-1:0]  out_data,
  input logic [SW-1:0] out_shift,
  input logic [SW-1:0] out_meas,
  input logic [SW-1:0] app_shift
);

  logic [W-1:0] lowmask;
  assign lowmask = ~({W{1'b1}} << out_shift);

  p_valid_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_meas_falls_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_first) |=> out_meas <= $past(out_meas));
  p_apply_at_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_last) |=> $stable(app_shift));
  p_zero_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_data & lowmask) == '0);
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_meas) && $stable(out_data)));

endmodule

bind bfp_shift_tracker bfp_shift_tracker_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
  .in_last(in_last), .out_valid(out_valid), .out_data(out_data),
  .out_shift(out_shift), .out_meas(out_meas), .app_shift(app_shift)
);

// File: tb/bfp_shift_tracker_bench.sv
`timescale 1ns/1ps
module bfp_shift_tracker_bench;
  localparam int W = 32;
  localparam int SW = 5;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_first = 0, in_last = 0, in_sign = 0;
  logic [W-1:0] in_data = '0;
  logic out_valid, out_first, out_last;
  logic [W-1:0] out_data;
  logic [SW-1:0] out_shift, out_meas;

  int checks = 0, errors = 0;
  int ref_app = 0, ref_min = W - 1;
  logic [W-1:0] ref_data = '0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bfp_shift_tracker #(.W(W)) u_bfp_shift_tracker (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
    .in_last(in_last), .in_data(in_data), .in_sign(in_sign),
    .out_valid(out_valid), .out_first(out_first), .out_last(out_last),
    .out_data(out_data), .out_shift(out_shift), .out_meas(out_meas));

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int ref_lead(input logic [W-1:0] d, input logic s);
    longint unsigned x;
    x = 64'(d ^ {W{s}});
    if (x <= 1) return W - 1;
    return W - $clog2(x + 1);
  endfunction

  task automatic send(input logic [W-1:0] d, input logic s,
                      input logic f, input logic l, input string req);
    int ld;
    in_valid = 1; in_data = d; in_sign = s; in_first = f; in_last = l;
    @(posedge clk); @(negedge clk);
    in_valid = 0; in_first = 0; in_last = 0;
    ld = ref_lead(d, s);
    ref_min = (f || ld < ref_min) ? ld : ref_min;
    ref_data = d << ref_app;
    chk(out_valid === 1'b1 && out_first === f && out_last === l, "R2",
        "markers", {out_valid, out_first, out_last}, {1'b1, f, l});
    chk(out_shift === SW'(ref_app), "R5", "out_shift", out_shift, ref_app);
    chk(out_data === ref_data, "R6", "out_data", out_data, ref_data);
    chk(out_meas === SW'(ref_min), req, "out_meas", out_meas, ref_min);
    if (l) ref_app = ref_min;
  endtask

  task automatic idle();
    @(posedge clk); @(negedge clk);
    chk(out_valid === 1'b0 && out_first === 1'b0 && out_last === 1'b0,
        "R2", "idle markers", {out_valid, out_first, out_last}, 0);
    chk(out_meas === SW'(ref_min) && out_data === ref_data, "R7",
        "idle hold", {out_meas, out_data}, {SW'(ref_min), ref_data});
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid === 0 && out_first === 0 && out_last === 0 && out_shift === 0
        && out_meas === SW'(W - 1), "R1", "reset state",
        {out_valid, out_shift, out_meas}, {1'b0, 5'd0, 5'd31});
    rst_n = 1;
    idle();
    chk(out_shift === 0, "R1", "applied shift after reset", out_shift, 0);

    // R3 / R8 sweep: every leading position, both signs, single-word vectors
    for (int s = 0; s < 2; s++)
      for (int p = -1; p < W; p++) begin
        logic [W-1:0] d;
        d = (p < 0) ? '0 : ((W'(1) << p) | (W'($urandom) & ((W'(1) << p) - 1)));
        if (s == 1) d = ~d;
        send(d, 1'(s), 1, 1, "R8");
        chk(ref_app == ref_lead(d, 1'(s)), "R3", "distance",
            ref_app, (p <= 0) ? W - 1 : W - 1 - p);
      end

    // R4 / R5 random vectors with gaps
    for (int v = 0; v < 40; v++) begin
      int len;
      len = 1 + int'($urandom % 8);
      for (int e = 0; e < len; e++) begin
        logic [W-1:0] d;
        logic sg;
        d = W'($urandom) >> ($urandom % W);
        sg = 1'($urandom);
        if (sg) d = ~d;
        send(d, sg, e == 0, e == len - 1, "R4");
        if ($urandom % 4 == 0) idle();
      end
      if (v % 3 == 0) idle();
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule